// File: doc/BRIEF.md
# PCM Sample FIFO with Replay Mode

This block buffers byte-wide PCM audio data written by a host and turns it into a stream of left and right signed 16-bit samples. The host writes sample bytes through a data port. It also writes a single control register and reads it back. A playback side takes one frame out of the buffer each time a sample-rate strobe arrives. A frame is one, two or four bytes, depending on whether samples are 8 or 16 bits wide and whether the stream is mono or stereo. Each channel value is scaled by a 4-bit volume before it is registered on the outputs.

The control register has two read-only status flags: full in bit 7 and empty in bit 6. It also holds three retained format fields: 16-bit select in bit 5, stereo select in bit 4 and volume in bits 3:0. The two top bits act as commands when written. Writing bit 7 alone flushes the buffer. Writing bits 7 and 6 together arms a replay mode. In replay mode the buffered bytes are played over and over and are never freed. Any other register write disarms replay, and the bytes already played are then released.

Top module: `pcm_loop_fifo`

## Requirements
- R1: After reset, all six retained control bits are 0, the buffer holds no bytes, replay mode is off and both outputs are 0. The register therefore reads 8'h40.
- R2: The buffer holds 2**ADDR_W bytes. Register bit 7 reads 1 exactly when that many bytes are stored.
- R3: A data write made while bit 7 reads 1 is discarded. It never reaches the output stream.
- R4: Register bit 6 reads 1 exactly when the buffer holds no bytes. Bits 7 and 6 are never 1 together.
- R5: A register write with bit 7 = 1 and bit 6 = 0 empties the buffer. After it, bit 6 reads 1 and none of the older bytes are played.
- R6: A register write with bits 7 and 6 both = 1 does not empty the buffer. It turns on replay mode. In replay mode, frames taken by the strobe do not lower the stored byte count, so bit 6 stays 0.
- R7: Any register write other than bits 7:6 = 2'b11 turns replay mode off. The bytes already played since the oldest retained byte are then freed. Normal draining resumes from the current play position.
- R8: Every register write stores write-data bits 5:0, and they read back unchanged in bits 5:0. Bit 5 = 1 selects 16-bit samples, bit 4 = 1 selects stereo, and bits 3:0 are the volume.
- R9: Each strobe that has a full frame available consumes 1 byte (8-bit mono), 2 bytes (8-bit stereo or 16-bit mono) or 4 bytes (16-bit stereo). A 16-bit sample is low byte first. In a stereo frame the left sample comes before the right.
- R10: In mono, both outputs carry the same sample. An 8-bit sample forms the 16-bit value {byte, 8'h00}.
- R11: Each output equals floor(sample * volume / 16), computed as signed arithmetic. Volume 0 gives 0 on both outputs.
- R12: A strobe that arrives while fewer bytes are stored than one frame needs consumes nothing, and both outputs keep their previous values.
- R13: In replay mode, when the play position reaches the newest byte it wraps to the oldest retained byte. A frame may straddle that wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value: {full, empty, 16-bit, stereo, volume} |
| fifo_we | input | 1 | Sample byte write strobe |
| fifo_wdata | input | 8 | Sample byte |
| smp_tick | input | 1 | Sample-rate strobe, one cycle per frame |
| out_left | output | 16 | Scaled left sample, signed |
| out_right | output | 16 | Scaled right sample, signed |

## Verification
The bench builds the block with ADDR_W = 4, so the buffer holds 16 bytes. At that size, filling to full, dropping writes while full and draining back to empty each take only a few dozen cycles. The random phase also reaches the full flag many times. The small depth keeps replay loops short as well. Within a short run, the replay play position wraps many times, including 4-byte stereo frames that straddle the wrap back to the oldest byte.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

    localparam int FULL_BIT  = 7;
    localparam int EMPTY_BIT = 6;
    localparam int FRAME_MAX = 4;

    typedef struct packed {
        logic       wide;
        logic       stereo;
        logic [3:0] vol;
    } pcm_fmt_t;

    typedef struct packed {
        logic signed [15:0] left;
        logic signed [15:0] right;
    } pcm_pair_t;

    function automatic logic [2:0] frame_len(input pcm_fmt_t f);
        case ({f.wide, f.stereo})
            2'b00:   return 3'd1;
            2'b11:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic signed [15:0] apply_vol(input logic signed [15:0] s,
                                                     input logic [3:0] v);
        logic signed [20:0] a;
        logic signed [20:0] b;
        logic signed [20:0] p;
        a = 21'(s);
        b = $signed({17'd0, v});
        p = a * b;
        return p[19:4];
    endfunction

endpackage

// File: rtl/pcm_ctrl_reg.sv
module pcm_ctrl_reg
    import pcm_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output pcm_fmt_t   fmt_q,
    output logic       loop_q,
    output logic       clr_req,
    output logic       fold_req
);
    logic both_top;

    assign both_top = wdata[FULL_BIT] && wdata[EMPTY_BIT];
    assign clr_req  = we && wdata[FULL_BIT] && !wdata[EMPTY_BIT];
    assign fold_req = we && !both_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= '0;
            loop_q <= 1'b0;
        end else if (we) begin
            fmt_q  <= pcm_fmt_t'(wdata[5:0]);
            loop_q <= both_top;
        end
    end
endmodule

// File: rtl/pcm_byte_store.sv
module pcm_byte_store
    import pcm_fifo_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 waddr,
    input  logic [7:0]                        wdata,
    input  logic [FRAME_MAX-1:0][ADDR_W-1:0]  raddr,
    output logic [FRAME_MAX-1:0][7:0]         rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar k = 0; k < FRAME_MAX; k++) begin : g_rd
        assign rdata[k] = mem[raddr[k]];
    end
endmodule

// File: rtl/pcm_frame_unpack.sv
module pcm_frame_unpack
    import pcm_fifo_pkg::*;
(
    input  logic [FRAME_MAX-1:0][7:0] bytes,
    input  pcm_fmt_t                  fmt,
    output pcm_pair_t                 pair
);
    logic signed [15:0] raw_l;
    logic signed [15:0] raw_r;

    always_comb begin
        if (fmt.wide) begin
            raw_l = {bytes[1], bytes[0]};
            raw_r = fmt.stereo ? {bytes[3], bytes[2]} : raw_l;
        end else begin
            raw_l = {bytes[0], 8'h00};
            raw_r = fmt.stereo ? {bytes[1], 8'h00} : raw_l;
        end
        pair.left  = apply_vol(raw_l, fmt.vol);
        pair.right = apply_vol(raw_r, fmt.vol);
    end
endmodule

// File: rtl/pcm_loop_fifo.sv
module pcm_loop_fifo
    import pcm_fifo_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               fifo_we,
    input  logic [7:0]         fifo_wdata,
    input  logic               smp_tick,
    output logic signed [15:0] out_left,
    output logic signed [15:0] out_right
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    pcm_fmt_t  fmt;
    logic      loop_on, clr_req, fold_req;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [CW-1:0]     count_q, count_n, played_q, played_n;
    logic [CW-1:0]     need;
    logic [CW:0]       off, step;
    logic              full, empty, frame_ok, take, push;
    logic [FRAME_MAX-1:0][ADDR_W-1:0] raddr;
    logic [FRAME_MAX-1:0][7:0]        rbytes;
    pcm_pair_t         pair;

    pcm_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
        .fmt_q(fmt), .loop_q(loop_on), .clr_req(clr_req), .fold_req(fold_req)
    );

    assign full      = (count_q == CW'(DEPTH));
    assign empty     = (count_q == '0);
    assign need      = CW'(frame_len(fmt));
    assign frame_ok  = (count_q >= need);
    assign take      = smp_tick && frame_ok;
    assign push      = fifo_we && !full && !clr_req;
    assign reg_rdata = {full, empty, fmt};

    // byte k of the next frame, wrapping to the oldest retained byte
    always_comb begin
        for (int k = 0; k < FRAME_MAX; k++) begin
            off = (CW+1)'(played_q) + (CW+1)'(k);
            if (off >= (CW+1)'(count_q)) off = off - (CW+1)'(count_q);
            raddr[k] = base_q + off[ADDR_W-1:0];
        end
    end

    pcm_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(push), .waddr(base_q + count_q[ADDR_W-1:0]),
        .wdata(fifo_wdata), .raddr(raddr), .rdata(rbytes)
    );

    pcm_frame_unpack u_unpack (.bytes(rbytes), .fmt(fmt), .pair(pair));

    always_comb begin
        base_n   = base_q;
        count_n  = count_q;
        played_n = played_q;
        step     = (CW+1)'(played_q) + (CW+1)'(need);
        if (take) begin
            if (loop_on) begin
                played_n = (step >= (CW+1)'(count_q)) ? CW'(step - (CW+1)'(count_q))
                                                       : CW'(step);
            end else begin
                base_n  = base_q + need[ADDR_W-1:0];
                count_n = count_q - need;
            end
        end
        if (push) count_n = count_n + CW'(1);
        if (clr_req) begin
            base_n   = '0;
            count_n  = '0;
            played_n = '0;
        end else if (fold_req) begin
            base_n   = base_n + played_n[ADDR_W-1:0];
            count_n  = count_n - played_n;
            played_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            count_q   <= '0;
            played_q  <= '0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            base_q   <= base_n;
            count_q  <= count_n;
            played_q <= played_n;
            if (take) begin
                out_left  <= pair.left;
                out_right <= pair.right;
            end
        end
    end
endmodule

module pcm_loop_fifo_chk #(
    parameter int ADDR_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic               fifo_we,
    input logic               smp_tick,
    input logic signed [15:0] out_left,
    input logic signed [15:0] out_right,
    input logic [ADDR_W:0]    count,
    input logic               frame_ok,
    input logic               loop_on
);
    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rdata[7] && reg_rdata[6]));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[7] && fifo_we && !reg_we && !smp_tick) |=> (reg_rdata[7] && $stable(count)));

    // R5
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_wdata[7:6] == 2'b10) |=> reg_rdata[6]);

    // R12
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_tick && !frame_ok) |=> ($stable(out_left) && $stable(out_right)));

    // R6
    loop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (loop_on && !reg_we) |=> (count >= $past(count)));

    // R11
    mute_out_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_tick && frame_ok && reg_rdata[3:0] == 4'd0) |=> (out_left == 0 && out_right == 0));

    // R8
    fmt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (reg_rdata[5:0] == $past(reg_wdata[5:0])));
endmodule

bind pcm_loop_fifo pcm_loop_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_we(fifo_we), .smp_tick(smp_tick),
    .out_left(out_left), .out_right(out_right), .count(count_q),
    .frame_ok(frame_ok), .loop_on(loop_on)
);

// File: tb/pcm_loop_fifo_tb.sv
`timescale 1ns/1ps
module pcm_loop_fifo_tb;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0, fifo_we = 1'b0, smp_tick = 1'b0;
    logic [7:0] reg_wdata = '0, fifo_wdata = '0;
    logic [7:0] reg_rdata;
    logic signed [15:0] out_left, out_right;

    int total = 0, bad = 0;
    logic [7:0] q[$];
    int  pl = 0;
    bit  lp = 0;
    logic [5:0] mf = '0;
    int  eL = 0, eR = 0;

    always #2 clk = ~clk;

    pcm_loop_fifo #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .smp_tick(smp_tick), .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int scale(input int s, input int v);
        return (s * v) >>> 4;
    endfunction

    task automatic chk_status(input string tag);
        int exp;
        exp = ((q.size() == DEPTH) ? 128 : 0) + ((q.size() == 0) ? 64 : 0) + int'(mf);
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic do_reg(input logic [7:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
        mf = v[5:0];
        if (v[7] && !v[6]) begin
            q.delete(); pl = 0; lp = 0;
        end else if (v[7] && v[6]) begin
            lp = 1;
        end else begin
            lp = 0;
            for (int i = 0; i < pl; i++) void'(q.pop_front());
            pl = 0;
        end
    endtask

    task automatic do_push(input logic [7:0] b);
        @(negedge clk); fifo_we = 1'b1; fifo_wdata = b;
        @(negedge clk); fifo_we = 1'b0;
        if (q.size() < DEPTH) q.push_back(b);
    endtask

    task automatic do_tick(input string tag);
        int n, l, r;
        logic [7:0] b [4];
        n = (mf[5] && mf[4]) ? 4 : ((mf[5] || mf[4]) ? 2 : 1);
        if (q.size() >= n) begin
            for (int k = 0; k < 4; k++) b[k] = q[(pl + k) % q.size()];
            if (mf[5]) begin
                l = int'($signed({b[1], b[0]}));
                r = mf[4] ? int'($signed({b[3], b[2]})) : l;
            end else begin
                l = int'($signed({b[0], 8'h00}));
                r = mf[4] ? int'($signed({b[1], 8'h00})) : l;
            end
            eL = scale(l, int'(mf[3:0]));
            eR = scale(r, int'(mf[3:0]));
            if (lp) pl = (pl + n) % q.size();
            else for (int i = 0; i < n; i++) void'(q.pop_front());
        end
        @(negedge clk); smp_tick = 1'b1;
        @(negedge clk); smp_tick = 1'b0;
        chk({tag, " left"},  int'(out_left),  eL);
        chk({tag, " right"}, int'(out_right), eR);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", int'(reg_rdata), 8'h40);
        chk("R1 left", int'(out_left), 0);
        chk("R1 right", int'(out_right), 0);
        do_reg(8'h0F);
        chk_status("R8 format readback");
        do_tick("R12 empty hold");
        do_push(8'h40);
        chk_status("R4 empty clears");
        do_tick("R10 8-bit mono");
        // R2 / R3: fill, overfill, drain
        for (int i = 0; i < DEPTH; i++) do_push(8'(i * 7 + 3));
        chk_status("R2 full flag");
        do_push(8'hEE);
        chk_status("R3 full write dropped");
        for (int i = 0; i < DEPTH; i++) do_tick("R3 drain order");
        chk_status("R4 empty after drain");
        do_tick("R3 no extra byte");
        // R9: 16-bit stereo, little endian, left first
        do_reg(8'h38);
        do_push(8'h01); do_push(8'h80); do_push(8'hFF); do_push(8'h7F);
        do_tick("R9 16-bit stereo");
        chk("R9 left value", int'(out_left), -16384);
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        do_tick("R12 partial frame");
        chk_status("R12 nothing consumed");
        do_push(8'h44);
        do_tick("R9 completed frame");
        do_reg(8'h28);
        do_push(8'h34); do_push(8'hC2);
        do_tick("R10 16-bit mono");
        do_reg(8'h1A);
        do_push(8'h90); do_push(8'h30);
        do_tick("R10 8-bit stereo");
        // R11: silence at volume 0
        do_reg(8'h10);
        do_push(8'h7F); do_push(8'h80);
        do_tick("R11 volume zero");
        chk("R11 silent", int'(out_left) + int'(out_right), 0);
        // R5: flush
        do_reg(8'h0F);
        do_push(8'h55); do_push(8'h66); do_push(8'h77);
        do_reg(8'h8F);
        chk_status("R5 flush empties");
        do_tick("R5 no old data");
        // R6 / R13: replay
        do_reg(8'hCF);
        do_push(8'h10); do_push(8'h20); do_push(8'h30);
        for (int i = 0; i < 7; i++) do_tick("R13 replay wrap");
        chk_status("R6 replay keeps bytes");
        // R7: disarm frees played bytes
        do_reg(8'h0F);
        chk_status("R7 played bytes freed");
        do_tick("R7 drain resumes");
        do_tick("R7 drain resumes");
        chk_status("R7 empty after drain");
        // R13: 4-byte frame straddling the wrap
        do_reg(8'hF8);
        for (int i = 0; i < 6; i++) do_push(8'(8'hA0 + i));
        for (int i = 0; i < 5; i++) do_tick("R13 stereo straddle");
        do_reg(8'h80);
        chk_status("R5 flush after replay");
        // random phase
        for (int it = 0; it < 600; it++) begin
            int a;
            a = int'($urandom_range(0, 19));
            if (a == 0) begin
                logic [7:0] v;
                v = 8'($urandom());
                v[7:6] = ($urandom_range(0, 9) < 6) ? 2'b00 :
                         (($urandom_range(0, 3) == 0) ? 2'b10 : 2'b11);
                do_reg(v);
                chk_status("R8 random register");
            end else if (a < 10) begin
                do_push(8'($urandom()));
            end else if (a < 18) begin
                do_tick("R9 random frame");
            end else begin
                chk_status("R4 random status");
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule